// File: doc/BRIEF.md
# Register Window Pointer Controller

This block keeps the current window pointer of a windowed register file together with a per-window invalid mask. It carries out the operations that move between windows: the call-side shift (save), the return-side shift (restore), return from trap, trap entry, and direct writes of the pointer or the mask. Every move is checked against the mask before it takes effect. Trap entry is the exception and always moves down one window.

When a save, restore or return-from-trap would land on a marked window, the block leaves the pointer where it is. It then raises a one-cycle overflow or underflow request for the trap logic. After a save or restore takes effect, it reports the window it left and the window it entered. The datapath uses these to read the add operands in the old window and write the sum in the new one.

On trap entry, the block drives a single register-file write port for two cycles. The first cycle stores the trapped program counter into local 1 of the new window. The second stores the next program counter into local 2. A busy flag is high while these writes run, and operations presented during that time are dropped.

Top module: `wptr_ctrl`

## Requirements
- R1: In the cycle after a synchronous reset, the pointer and the mask read zero. The overflow, underflow, add-report, write-enable and busy outputs are all low.
- R2: A save (op code 1) on an unmarked target moves the pointer down by one modulo the window count, so 0 goes to 7 with eight windows. The result is visible on the clock edge that samples the op.
- R3: A save whose target window has its mask bit set raises `ovf_o` for exactly one cycle. The pointer and the mask keep their values and no add report is issued.
- R4: A restore (op code 2) moves the pointer up by one modulo the window count, so 7 goes to 0. If the target's mask bit is set, it raises `unf_o` for one cycle and leaves the pointer unchanged.
- R5: A return from trap (op code 3) moves the pointer up and is checked like a restore. It never issues an add report.
- R6: Trap entry (op code 4) moves the pointer down by one whatever the mask holds, and never raises overflow.
- R7: After trap entry, the write port is enabled for exactly two cycles, aimed at the new window. The first cycle writes register index 17 with `trap_pc_i`, and the second writes index 18 with the `trap_npc_i` value captured with the op. `busy_o` is high during exactly those two cycles.
- R8: Any op presented while `busy_o` is high is ignored, and the pointer and mask are left unchanged.
- R9: A pointer write (op code 5) loads the low pointer bits of `wr_data_i`, and a mask write (op code 6) loads the low window-count bits. Both take effect on the next edge without a mask check. Op code 0 does nothing.
- R10: A save or restore that takes effect pulses `add_vld_o` for one cycle. In that cycle `add_src_o` holds the previous pointer and `add_dst_o` holds the new one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_i | input | 3 | Operation code, sampled each edge |
| wr_data_i | input | 32 | Value for pointer or mask writes |
| trap_pc_i | input | 32 | Program counter saved on trap entry |
| trap_npc_i | input | 32 | Next program counter saved on trap entry |
| cur_ptr_o | output | 3 | Current window pointer |
| mask_o | output | 8 | Window invalid mask |
| ovf_o | output | 1 | Window overflow trap request |
| unf_o | output | 1 | Window underflow trap request |
| add_vld_o | output | 1 | Save or restore took effect |
| add_src_o | output | 3 | Window the add reads from |
| add_dst_o | output | 3 | Window the add writes to |
| rf_we_o | output | 1 | Register-file write enable for trap saves |
| rf_win_o | output | 3 | Window of the trap save write |
| rf_idx_o | output | 5 | Logical register index of the trap save write |
| rf_data_o | output | 32 | Trap save write data |
| busy_o | output | 1 | Trap save sequence in progress |

## Verification
The bench builds the block with its defaults: eight windows and 32-bit data. With these values, both wrap points (0 to 7 on a save or trap, 7 to 0 on a restore) can be reached in a few operations. Every mask bit position is also directly addressable, so a mark can be placed next to any pointer value. The 32-bit data width lets the trap save be checked with distinct program-counter patterns. Ops issued during the two busy cycles show that a dropped operation leaves the pointer intact.

// File: rtl/wptr_pkg.sv
package wptr_pkg;
  typedef enum logic [2:0] {
    OP_NOP     = 3'd0,
    OP_SAVE    = 3'd1,
    OP_RESTORE = 3'd2,
    OP_RETT    = 3'd3,
    OP_TRAP    = 3'd4,
    OP_WPTR    = 3'd5,
    OP_WMASK   = 3'd6
  } wop_e;

  function automatic int unsigned wrap_dec(int unsigned p, int unsigned n);
    return (p == 0) ? n - 1 : p - 1;
  endfunction

  function automatic int unsigned wrap_inc(int unsigned p, int unsigned n);
    return (p == n - 1) ? 0 : p + 1;
  endfunction
endpackage

// File: rtl/wptr_target.sv
module wptr_target
  import wptr_pkg::*;
#(
  parameter int NWIN  = 8,
  parameter int PTR_W = $clog2(NWIN)
) (
  input  logic [PTR_W-1:0] cur_i,
  input  logic [NWIN-1:0]  mask_i,
  input  wop_e             op_i,
  output logic [PTR_W-1:0] tgt_o,
  output logic             marked_o
);
  localparam logic [PTR_W-1:0] TOP = PTR_W'(NWIN - 1);

  logic [PTR_W-1:0] up_w, down_w;

  always_comb begin
    up_w   = (cur_i == TOP) ? '0 : PTR_W'(cur_i + 1'b1);
    down_w = (cur_i == '0) ? TOP : PTR_W'(cur_i - 1'b1);
    tgt_o  = (op_i == OP_SAVE || op_i == OP_TRAP) ? down_w : up_w;
    marked_o = mask_i[tgt_o];
  end
endmodule

// File: rtl/wptr_trapseq.sv
module wptr_trapseq #(
  parameter int PTR_W  = 3,
  parameter int DATA_W = 32,
  parameter int IDX_W  = 5,
  parameter int LOC_PC  = 17,
  parameter int LOC_NPC = 18
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [PTR_W-1:0]  win_i,
  input  logic [DATA_W-1:0] pc_i,
  input  logic [DATA_W-1:0] npc_i,
  output logic              we_o,
  output logic [PTR_W-1:0]  win_o,
  output logic [IDX_W-1:0]  idx_o,
  output logic [DATA_W-1:0] data_o,
  output logic              busy_o
);
  typedef enum logic [1:0] {PH_IDLE, PH_PC, PH_NPC} phase_e;
  localparam logic [IDX_W-1:0] IDX_PC  = IDX_W'(LOC_PC);
  localparam logic [IDX_W-1:0] IDX_NPC = IDX_W'(LOC_NPC);

  phase_e            phase_q;
  logic [DATA_W-1:0] npc_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_IDLE;
      we_o    <= 1'b0;
      win_o   <= '0;
      idx_o   <= '0;
      data_o  <= '0;
      npc_q   <= '0;
    end else begin
      case (phase_q)
        PH_IDLE: if (start_i) begin
          phase_q <= PH_PC;
          we_o    <= 1'b1;
          win_o   <= win_i;
          idx_o   <= IDX_PC;
          data_o  <= pc_i;
          npc_q   <= npc_i;
        end
        PH_PC: begin
          phase_q <= PH_NPC;
          idx_o   <= IDX_NPC;
          data_o  <= npc_q;
        end
        default: begin
          phase_q <= PH_IDLE;
          we_o    <= 1'b0;
        end
      endcase
    end
  end

  assign busy_o = (phase_q != PH_IDLE);

  // R7: the second save write follows the first into the same window
  assert_npc_follows_R7: assert property (@(posedge clk) disable iff (rst)
    (we_o && idx_o == IDX_NPC) |-> ($past(we_o) && $past(idx_o) == IDX_PC && $stable(win_o)));
  // R7: the enable never lasts beyond two cycles
  assert_two_writes_R7: assert property (@(posedge clk) disable iff (rst)
    ($past(we_o) && $past(idx_o) == IDX_NPC) |-> !we_o);
endmodule

// File: rtl/wptr_ctrl.sv
module wptr_ctrl
  import wptr_pkg::*;
#(
  parameter int NWIN   = 8,
  parameter int DATA_W = 32,
  parameter int IDX_W  = 5
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [2:0]               op_i,
  input  logic [DATA_W-1:0]        wr_data_i,
  input  logic [DATA_W-1:0]        trap_pc_i,
  input  logic [DATA_W-1:0]        trap_npc_i,
  output logic [$clog2(NWIN)-1:0]  cur_ptr_o,
  output logic [NWIN-1:0]          mask_o,
  output logic                     ovf_o,
  output logic                     unf_o,
  output logic                     add_vld_o,
  output logic [$clog2(NWIN)-1:0]  add_src_o,
  output logic [$clog2(NWIN)-1:0]  add_dst_o,
  output logic                     rf_we_o,
  output logic [$clog2(NWIN)-1:0]  rf_win_o,
  output logic [IDX_W-1:0]         rf_idx_o,
  output logic [DATA_W-1:0]        rf_data_o,
  output logic                     busy_o
);
  localparam int PTR_W = $clog2(NWIN);

  wop_e             op_w;
  logic [PTR_W-1:0] ptr_q, tgt_w;
  logic [NWIN-1:0]  mask_q;
  logic             marked_w, accept_w, busy_w;
  logic             ovf_q, unf_q, add_vld_q;
  logic [PTR_W-1:0] add_src_q, add_dst_q;

  assign op_w     = wop_e'(op_i);
  assign accept_w = !busy_w;

  wptr_target #(.NWIN(NWIN), .PTR_W(PTR_W)) u_target (
    .cur_i(ptr_q), .mask_i(mask_q), .op_i(op_w),
    .tgt_o(tgt_w), .marked_o(marked_w)
  );

  wptr_trapseq #(.PTR_W(PTR_W), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_seq (
    .clk(clk), .rst(rst),
    .start_i(accept_w && op_w == OP_TRAP),
    .win_i(tgt_w), .pc_i(trap_pc_i), .npc_i(trap_npc_i),
    .we_o(rf_we_o), .win_o(rf_win_o), .idx_o(rf_idx_o),
    .data_o(rf_data_o), .busy_o(busy_w)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q     <= '0;
      mask_q    <= '0;
      ovf_q     <= 1'b0;
      unf_q     <= 1'b0;
      add_vld_q <= 1'b0;
      add_src_q <= '0;
      add_dst_q <= '0;
    end else begin
      ovf_q     <= 1'b0;
      unf_q     <= 1'b0;
      add_vld_q <= 1'b0;
      if (accept_w) begin
        case (op_w)
          OP_SAVE, OP_RESTORE: begin
            if (marked_w) begin
              ovf_q <= (op_w == OP_SAVE);
              unf_q <= (op_w == OP_RESTORE);
            end else begin
              ptr_q     <= tgt_w;
              add_vld_q <= 1'b1;
              add_src_q <= ptr_q;
              add_dst_q <= tgt_w;
            end
          end
          OP_RETT: begin
            if (marked_w) unf_q <= 1'b1;
            else          ptr_q <= tgt_w;
          end
          OP_TRAP:  ptr_q  <= tgt_w;
          OP_WPTR:  ptr_q  <= wr_data_i[PTR_W-1:0];
          OP_WMASK: mask_q <= wr_data_i[NWIN-1:0];
          default: ;
        endcase
      end
    end
  end

  assign cur_ptr_o = ptr_q;
  assign mask_o    = mask_q;
  assign ovf_o     = ovf_q;
  assign unf_o     = unf_q;
  assign add_vld_o = add_vld_q;
  assign add_src_o = add_src_q;
  assign add_dst_o = add_dst_q;
  assign busy_o    = busy_w;

  // R2: an accepted save without overflow lands one window down
  assert_save_step_R2: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(busy_w) && $past(op_i) == 3'(OP_SAVE) && !ovf_q)
      |-> (int'(ptr_q) == wrap_dec(int'($past(ptr_q)), NWIN)));
  // R3: a window trap leaves pointer and mask untouched
  assert_trap_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && (ovf_q || unf_q)) |-> ($stable(ptr_q) && $stable(mask_q) && !add_vld_q));
  // R4: overflow and underflow never coincide
  assert_one_trap_R4: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ovf_q, unf_q}));
  // R6: trap entry ignores the mask
  assert_trap_entry_R6: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(busy_w) && $past(op_i) == 3'(OP_TRAP))
      |-> (!ovf_q && int'(ptr_q) == wrap_dec(int'($past(ptr_q)), NWIN)));
  // R8: nothing moves while the save sequence runs
  assert_busy_freeze_R8: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(busy_w)) |-> ($stable(ptr_q) && $stable(mask_q)));
  // R10: the add report names adjacent windows
  assert_add_adjacent_R10: assert property (@(posedge clk) disable iff (rst)
    add_vld_q |-> (int'(add_dst_q) == wrap_dec(int'(add_src_q), NWIN) ||
                   int'(add_dst_q) == wrap_inc(int'(add_src_q), NWIN)));
endmodule

// File: tb/wptr_ctrl_bench.sv
module wptr_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  op_i = 3'd0;
  logic [31:0] wr_data_i = '0, trap_pc_i = '0, trap_npc_i = '0;
  logic [2:0]  cur_ptr_o, add_src_o, add_dst_o, rf_win_o;
  logic [7:0]  mask_o;
  logic        ovf_o, unf_o, add_vld_o, rf_we_o, busy_o;
  logic [4:0]  rf_idx_o;
  logic [31:0] rf_data_o;
  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  wptr_ctrl u_wptr_ctrl (
    .clk(clk), .rst(rst), .op_i(op_i), .wr_data_i(wr_data_i),
    .trap_pc_i(trap_pc_i), .trap_npc_i(trap_npc_i),
    .cur_ptr_o(cur_ptr_o), .mask_o(mask_o), .ovf_o(ovf_o), .unf_o(unf_o),
    .add_vld_o(add_vld_o), .add_src_o(add_src_o), .add_dst_o(add_dst_o),
    .rf_we_o(rf_we_o), .rf_win_o(rf_win_o), .rf_idx_o(rf_idx_o),
    .rf_data_o(rf_data_o), .busy_o(busy_o)
  );

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // present an op for one edge; returns at the following falling edge
  task automatic issue(logic [2:0] op, logic [31:0] data);
    op_i = op; wr_data_i = data;
    @(negedge clk);
    op_i = 3'd0;
  endtask

  task automatic t_reset;
    check("R1", "ptr", 32'(cur_ptr_o), 0);
    check("R1", "mask", 32'(mask_o), 0);
    check("R1", "flags", {27'd0, ovf_o, unf_o, add_vld_o, rf_we_o, busy_o}, 0);
  endtask

  task automatic t_save_restore_wrap;
    issue(3'd1, 0);
    check("R2", "save wrap ptr", 32'(cur_ptr_o), 7);
    check("R10", "add report", {add_vld_o, 5'd0, add_src_o, add_dst_o}, {1'b1, 5'd0, 3'd0, 3'd7});
    issue(3'd1, 0);
    check("R2", "second save ptr", 32'(cur_ptr_o), 6);
    issue(3'd5, 32'hFFFF_FFF7);
    check("R9", "pointer write", 32'(cur_ptr_o), 7);
    check("R10", "no add on write", 32'(add_vld_o), 0);
    issue(3'd2, 0);
    check("R4", "restore wrap ptr", 32'(cur_ptr_o), 0);
    check("R10", "restore report", {add_vld_o, 5'd0, add_src_o, add_dst_o}, {1'b1, 5'd0, 3'd7, 3'd0});
    @(negedge clk);
    check("R10", "report one cycle", 32'(add_vld_o), 0);
  endtask

  task automatic t_overflow;
    issue(3'd6, 32'hFFFF_FF04);
    check("R9", "mask write", 32'(mask_o), 32'h04);
    issue(3'd5, 3);
    issue(3'd1, 0);
    check("R3", "ovf raised", 32'(ovf_o), 1);
    check("R3", "ptr held", 32'(cur_ptr_o), 3);
    check("R3", "no add", 32'(add_vld_o), 0);
    @(negedge clk);
    check("R3", "ovf one cycle", 32'(ovf_o), 0);
    issue(3'd0, 0);
    check("R9", "nop keeps ptr", 32'(cur_ptr_o), 3);
  endtask

  task automatic t_underflow;
    issue(3'd6, 32'h10);
    issue(3'd2, 0);
    check("R4", "unf on restore", {30'd0, unf_o, ovf_o}, 2);
    check("R4", "ptr held", 32'(cur_ptr_o), 3);
    issue(3'd3, 0);
    check("R5", "unf on rett", 32'(unf_o), 1);
    check("R5", "ptr held", 32'(cur_ptr_o), 3);
    issue(3'd6, 0);
    issue(3'd3, 0);
    check("R5", "rett moves up", 32'(cur_ptr_o), 4);
    check("R5", "rett no add/unf", {30'd0, add_vld_o, unf_o}, 0);
  endtask

  task automatic t_trap_entry;
    issue(3'd6, 32'hFF);
    issue(3'd5, 0);
    trap_pc_i = 32'hDEAD_0040; trap_npc_i = 32'hDEAD_0044;
    op_i = 3'd4;
    @(negedge clk);
    op_i = 3'd0; trap_pc_i = '0; trap_npc_i = '0;
    check("R6", "trap ptr wraps", 32'(cur_ptr_o), 7);
    check("R6", "no ovf", 32'(ovf_o), 0);
    check("R7", "pc write", {rf_we_o, busy_o, 19'd0, rf_win_o, 3'd0, rf_idx_o},
          {1'b1, 1'b1, 19'd0, 3'd7, 3'd0, 5'd17});
    check("R7", "pc data", rf_data_o, 32'hDEAD_0040);
    @(negedge clk);
    check("R7", "npc write", {rf_we_o, busy_o, 19'd0, rf_win_o, 3'd0, rf_idx_o},
          {1'b1, 1'b1, 19'd0, 3'd7, 3'd0, 5'd18});
    check("R7", "npc data", rf_data_o, 32'hDEAD_0044);
    @(negedge clk);
    check("R7", "sequence ends", {30'd0, rf_we_o, busy_o}, 0);
  endtask

  task automatic t_busy_ignore;
    issue(3'd6, 0);
    issue(3'd5, 5);
    issue(3'd4, 0);
    check("R6", "trap ptr", 32'(cur_ptr_o), 4);
    issue(3'd1, 0);
    issue(3'd6, 32'h0F);
    check("R8", "ptr during busy", 32'(cur_ptr_o), 4);
    check("R8", "mask during busy", 32'(mask_o), 0);
    check("R8", "no add during busy", 32'(add_vld_o), 0);
    issue(3'd1, 0);
    check("R2", "save after busy", 32'(cur_ptr_o), 3);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_save_restore_wrap();
    t_overflow();
    t_underflow();
    t_trap_entry();
    t_busy_ignore();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; failures++;
      $display("FAIL watchdog actual=expired expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule